// File: doc/BRIEF.md
# Serial Shadow-RAM Command Controller

This block is the serial slave side of a small volatile memory that has a nonvolatile twin. A host selects the block with an active-low select. It clocks 8-bit commands in on a serial data line, most significant bit first, and sends write data the same way. Read data comes back on a serial output. The memory holds sixteen words. A store copies the working array into the shadow array. A recall copies the shadow array back into the working array. Either one holds `busy` for a fixed, parameterised number of clock cycles.

All pins are brought into the `clk` domain through two-flop synchronisers. Edges of the serial clock are found by comparing the synchronised level with its value one cycle earlier, so the serial clock may stop at any point and resume later. Two protection flags guard the shadow array. The write-enable flag gates memory writes and stores. The recalled flag records that the user has recalled at least once since power-up. A store runs only when both flags are set. Power-up recalls the shadow into the working array automatically, but that automatic recall does not set the recalled flag.

The serial front end is a five-state machine:
- HUNT waits for a 1 on the data line while selected and not busy. HUNT goes to INSTR.
- INSTR collects the remaining seven command bits. On the eighth bit it goes to WDATA for a write, to RDATA for a read, and to DRAIN for every other command or when busy.
- WDATA goes to DRAIN after 16 data bits.
- RDATA shifts data out until deselect.
- Any state returns to HUNT when select rises.

The copy engine has three states: IDLE, RECALL and STORE. Each copy state returns to IDLE after the last cycle of its count.

Top module: `shadow_ram_serial`

## Requirements
- R1: While `por_n` is low, `busy`, `so_oe` and `autostore_en` are low. After `por_n` rises, `busy` goes high for a power-up recall. Afterwards word i of the memory reads as SEED + i (default SEED = 16'h5A00).
- R2: A command is 8 bits, sampled on rising serial-clock edges while `cs_n` is low, MSB first. Bit 7 is 1 and bits 6:3 are the word address. Bits 2:0 select the command: 000 write-disable, 001 store, 010 autostore-enable, 011 write, 100 write-enable, 101 recall, 110 and 111 read.
- R3: After `cs_n` falls, 0 bits are skipped. The first 1 is taken as bit 7 of the command.
- R4: A read returns the 16-bit word MSB first on `so`, which changes after falling serial-clock edges. `so_oe` is high only in the read data phase and is low while `cs_n` is high.
- R5: A write takes the 16 data bits that follow the command, MSB first. The word changes only after all 16 bits arrive. Raising `cs_n` earlier leaves it unchanged.
- R6: Write-enable sets the write-enable flag and write-disable clears it. A write while the flag is clear has no effect.
- R7: A store starts only when both the write-enable flag and the recalled flag are set. Otherwise `busy` stays low and the shadow array is unchanged.
- R8: A recall command, or a falling edge on `recall_n`, copies the shadow array into the working array and sets the recalled flag. `busy` is high for exactly COPY_CYCLES cycles.
- R9: While `busy` is high, no start bit is accepted, so a whole command sent in that window has no effect.
- R10: When a store completes, the write-enable flag is cleared.
- R11: The serial clock may stop at any point of a command or data phase. Shifting resumes from the same bit when it restarts.
- R12: Autostore-enable sets `autostore_en`, which stays high until power-on reset and changes nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| cs_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock, may be stopped |
| si | input | 1 | Serial data in |
| recall_n | input | 1 | Hardware recall request, falling-edge active |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for the `so` pad driver |
| busy | output | 1 | A recall or store copy is running |
| autostore_en | output | 1 | Autostore has been enabled |

## Verification
The hardest situation to reach is a complete command arriving while a copy is running. The bench makes it by issuing a recall and then sending a full write-disable frame at once. The frame is short enough to fit inside the COPY_CYCLES window, and the bench confirms `busy` is still high after it ends. A later write then proves the flag was never cleared. An ignored store is made visible by rewriting a word and then recalling, which shows the shadow still holds its power-up pattern.

// File: rtl/srs_pkg.sv
package srs_pkg;

    localparam int INSTR_W = 8;
    localparam int ADDR_W  = 4;

    typedef enum logic [2:0] {
        OP_WRDIS  = 3'b000,
        OP_STORE  = 3'b001,
        OP_ASEN   = 3'b010,
        OP_WRITE  = 3'b011,
        OP_WREN   = 3'b100,
        OP_RECALL = 3'b101,
        OP_READ0  = 3'b110,
        OP_READ1  = 3'b111
    } op_e;

    typedef enum logic [2:0] {
        FS_HUNT,
        FS_INSTR,
        FS_WDATA,
        FS_RDATA,
        FS_DRAIN
    } fstate_e;

    typedef enum logic [1:0] {
        ES_IDLE,
        ES_RECALL,
        ES_STORE
    } estate_e;

endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
    parameter int               WIDTH   = 4,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
                else        chain <= {chain[STAGES-2:0], d[b]};
            end
            assign q[b] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/srs_nvcore.sv
module srs_nvcore
    import srs_pkg::*;
#(
    parameter int                DATA_W      = 16,
    parameter int                COPY_CYCLES = 256,
    parameter logic [DATA_W-1:0] SEED        = 16'h5A00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              rcl_req,
    input  logic              sto_req,
    output logic              busy,
    output logic              sto_done
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int CNT_W = $clog2(COPY_CYCLES + 1);

    logic [DATA_W-1:0] ram    [DEPTH];
    logic [DATA_W-1:0] shadow [DEPTH];
    estate_e           est, est_n;
    logic [CNT_W-1:0]  cnt;
    logic              boot;
    logic              last;

    assign last = (cnt == CNT_W'(COPY_CYCLES - 1));

    // engine next state
    always_comb begin
        est_n = est;
        unique case (est)
            ES_IDLE: begin
                if (boot || rcl_req) est_n = ES_RECALL;
                else if (sto_req)    est_n = ES_STORE;
            end
            ES_RECALL, ES_STORE: begin
                if (last) est_n = ES_IDLE;
            end
            default: est_n = ES_IDLE;
        endcase
    end

    // engine state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            est  <= ES_IDLE;
            cnt  <= '0;
            boot <= 1'b1;
        end else begin
            est  <= est_n;
            boot <= 1'b0;
            if (est == ES_IDLE) cnt <= '0;
            else                cnt <= cnt + CNT_W'(1);
        end
    end

    // working array
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ram[i] <= '0;
        end else if (est == ES_RECALL && last) begin
            for (int i = 0; i < DEPTH; i++) ram[i] <= shadow[i];
        end else if (wr_en && est == ES_IDLE) begin
            ram[wr_addr] <= wr_data;
        end
    end

    // shadow array
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) shadow[i] <= SEED + DATA_W'(i);
        end else if (est == ES_STORE && last) begin
            for (int i = 0; i < DEPTH; i++) shadow[i] <= ram[i];
        end
    end

    assign rd_data  = ram[rd_addr];
    assign busy     = (est != ES_IDLE);
    assign sto_done = (est == ES_STORE) && last;

    // copy length watcher
    logic [CNT_W-1:0] chk_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    chk_len <= '0;
        else if (busy) chk_len <= chk_len + CNT_W'(1);
        else           chk_len <= '0;
    end

    // R8
    copy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (chk_len == CNT_W'(COPY_CYCLES)));

    // R7
    store_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (est == ES_IDLE && est_n == ES_STORE) |-> sto_req);

endmodule

// File: rtl/srs_frontend.sv
module srs_frontend
    import srs_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sck_s,
    input  logic              si_s,
    input  logic              recall_n_s,
    input  logic              busy,
    input  logic              sto_done,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rcl_req,
    output logic              sto_req,
    output logic              so,
    output logic              so_oe,
    output logic              autostore_en
);

    localparam int CNT_W = $clog2(DATA_W + 1);

    fstate_e              fst, fst_n;
    logic                 sck_d, rcl_d;
    logic [DATA_W-1:0]    sh, rd_sh;
    logic [CNT_W-1:0]     cnt;
    logic [ADDR_W-1:0]    addr_q;
    logic                 wel, prl, asen, so_q;
    logic                 rise, fall, pin_rcl, decode_hit, cmd_ok, data_last;
    logic [INSTR_W-1:0]   instr_now;
    op_e                  op_now;

    assign rise       = sck_s & ~sck_d;
    assign fall       = ~sck_s & sck_d;
    assign pin_rcl    = rcl_d & ~recall_n_s;
    assign instr_now  = {sh[INSTR_W-2:0], si_s};
    assign op_now     = op_e'(instr_now[2:0]);
    assign rd_addr    = instr_now[6:3];
    assign decode_hit = !cs_n_s && (fst == FS_INSTR) && rise
                        && (cnt == CNT_W'(INSTR_W - 1));
    assign cmd_ok     = decode_hit && !busy;
    assign data_last  = !cs_n_s && (fst == FS_WDATA) && rise
                        && (cnt == CNT_W'(DATA_W - 1));

    assign wr_en   = data_last && wel && !busy;
    assign wr_addr = addr_q;
    assign wr_data = {sh[DATA_W-2:0], si_s};
    assign sto_req = cmd_ok && (op_now == OP_STORE) && wel && prl;
    assign rcl_req = !busy && ((decode_hit && op_now == OP_RECALL) || pin_rcl);

    // next state
    always_comb begin
        fst_n = fst;
        if (cs_n_s) begin
            fst_n = FS_HUNT;
        end else begin
            unique case (fst)
                FS_HUNT: begin
                    if (rise && si_s && !busy) fst_n = FS_INSTR;
                end
                FS_INSTR: begin
                    if (decode_hit) begin
                        if (busy)                                         fst_n = FS_DRAIN;
                        else if (op_now == OP_WRITE)                      fst_n = FS_WDATA;
                        else if (op_now == OP_READ0 || op_now == OP_READ1) fst_n = FS_RDATA;
                        else                                              fst_n = FS_DRAIN;
                    end
                end
                FS_WDATA: begin
                    if (data_last) fst_n = FS_DRAIN;
                end
                FS_RDATA, FS_DRAIN: fst_n = fst;
                default: fst_n = FS_HUNT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fst <= FS_HUNT;
        else        fst <= fst_n;
    end

    // shifting datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d  <= 1'b0;
            rcl_d  <= 1'b1;
            sh     <= '0;
            rd_sh  <= '0;
            cnt    <= '0;
            addr_q <= '0;
            so_q   <= 1'b0;
        end else begin
            sck_d <= sck_s;
            rcl_d <= recall_n_s;
            if (cs_n_s) begin
                cnt <= '0;
            end else begin
                unique case (fst)
                    FS_HUNT: begin
                        if (rise && si_s && !busy) begin
                            sh  <= DATA_W'(1);
                            cnt <= CNT_W'(1);
                        end
                    end
                    FS_INSTR: begin
                        if (rise) begin
                            sh <= {sh[DATA_W-2:0], si_s};
                            if (decode_hit) begin
                                cnt    <= '0;
                                addr_q <= rd_addr;
                                rd_sh  <= rd_data;
                                so_q   <= 1'b0;
                            end else begin
                                cnt <= cnt + CNT_W'(1);
                            end
                        end
                    end
                    FS_WDATA: begin
                        if (rise) begin
                            sh  <= {sh[DATA_W-2:0], si_s};
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    FS_RDATA: begin
                        if (fall) begin
                            so_q  <= rd_sh[DATA_W-1];
                            rd_sh <= {rd_sh[DATA_W-2:0], 1'b0};
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // protection and status flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel  <= 1'b0;
            prl  <= 1'b0;
            asen <= 1'b0;
        end else begin
            if (sto_done)                           wel <= 1'b0;
            else if (cmd_ok && op_now == OP_WREN)   wel <= 1'b1;
            else if (cmd_ok && op_now == OP_WRDIS)  wel <= 1'b0;
            if (rcl_req)                            prl <= 1'b1;
            if (cmd_ok && op_now == OP_ASEN)        asen <= 1'b1;
        end
    end

    assign so           = so_q;
    assign so_oe        = (fst == FS_RDATA);
    assign autostore_en = asen;

    // R4
    so_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !so_oe);

    // R9
    busy_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && fst == FS_HUNT) |=> (fst != FS_INSTR));

    // R10
    wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sto_done |=> !wel);

    // R12
    asen_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        autostore_en |=> autostore_en);

    // R5
    write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (fst == FS_WDATA && $stable(cs_n_s)));

endmodule

// File: rtl/shadow_ram_serial.sv
module shadow_ram_serial
    import srs_pkg::*;
#(
    parameter int                DATA_W      = 16,
    parameter int                COPY_CYCLES = 256,
    parameter logic [DATA_W-1:0] SEED        = 16'h5A00,
    parameter int                SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic recall_n,
    output logic so,
    output logic so_oe,
    output logic busy,
    output logic autostore_en
);

    logic [3:0]        pins_s;
    logic              wr_en, rcl_req, sto_req, sto_done;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data, rd_data;

    srs_sync #(
        .WIDTH   (4),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b1100)
    ) u_sync (
        .clk   (clk),
        .rst_n (por_n),
        .d     ({cs_n, recall_n, sck, si}),
        .q     (pins_s)
    );

    srs_frontend #(
        .DATA_W (DATA_W)
    ) u_front (
        .clk          (clk),
        .rst_n        (por_n),
        .cs_n_s       (pins_s[3]),
        .sck_s        (pins_s[1]),
        .si_s         (pins_s[0]),
        .recall_n_s   (pins_s[2]),
        .busy         (busy),
        .sto_done     (sto_done),
        .rd_data      (rd_data),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .rd_addr      (rd_addr),
        .rcl_req      (rcl_req),
        .sto_req      (sto_req),
        .so           (so),
        .so_oe        (so_oe),
        .autostore_en (autostore_en)
    );

    srs_nvcore #(
        .DATA_W      (DATA_W),
        .COPY_CYCLES (COPY_CYCLES),
        .SEED        (SEED)
    ) u_core (
        .clk      (clk),
        .rst_n    (por_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .rcl_req  (rcl_req),
        .sto_req  (sto_req),
        .busy     (busy),
        .sto_done (sto_done)
    );

endmodule

// File: tb/sim_shadow_ram_serial.sv
`timescale 1ns/1ps
module sim_shadow_ram_serial;

    localparam int          DW   = 16;
    localparam int          CC   = 256;
    localparam logic [15:0] SEED = 16'h5A00;
    localparam int          HALF = 6;

    localparam logic [2:0] C_WRDIS = 3'b000, C_STORE = 3'b001, C_ASEN = 3'b010,
                           C_WRITE = 3'b011, C_WREN = 3'b100, C_RCL = 3'b101;

    logic clk = 1'b0, por_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0, recall_n = 1'b1;
    logic so, so_oe, busy, autostore_en;

    int n_vec = 0, n_bad = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [15:0] word;
        string       tag;
    } exp_t;
    exp_t expq[$];

    always #2.5 clk = ~clk;

    shadow_ram_serial #(.DATA_W(DW), .COPY_CYCLES(CC), .SEED(SEED)) u0 (
        .clk(clk), .por_n(por_n), .cs_n(cs_n), .sck(sck), .si(si),
        .recall_n(recall_n), .so(so), .so_oe(so_oe), .busy(busy),
        .autostore_en(autostore_en)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(logic b);
        si = b;
        tick(HALF);
        sck = 1'b1;
        tick(HALF);
        sck = 1'b0;
    endtask

    task automatic send(logic [31:0] v, int n);
        for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic sel();
        cs_n = 1'b0;
        tick(4);
    endtask

    task automatic desel();
        si = 1'b0;
        tick(4);
        cs_n = 1'b1;
        tick(8);
    endtask

    function automatic logic [7:0] ins(logic [3:0] a, logic [2:0] op);
        return {1'b1, a, op};
    endfunction

    task automatic cmd(logic [2:0] op);
        sel(); send(32'(ins(4'd0, op)), 8); desel();
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        sel(); send(32'(ins(a, C_WRITE)), 8); send(32'(d), 16); desel();
    endtask

    // driver side of the scoreboard: queue the expected word, then clock the frame
    task automatic rd(logic [3:0] a, logic [15:0] exp, string tag, logic lsb, int lead);
        exp_t e;
        e.word = exp;
        e.tag  = tag;
        expq.push_back(e);
        sel();
        if (lead > 0) send(32'd0, lead);
        send(32'(ins(a, {2'b11, lsb})), 8);
        send(32'd0, 16);
        desel();
    endtask

    task automatic wait_idle();
        int g = 0;
        while (busy && g < 5000) begin
            tick(1);
            g++;
        end
    endtask

    // monitor side of the scoreboard
    initial begin
        logic [15:0] word = '0;
        int nbits = 0;
        forever begin
            @(posedge sck or posedge cs_n);
            if (cs_n) begin
                nbits = 0;
            end else if (so_oe) begin
                word = {word[14:0], so};
                nbits++;
                if (nbits == 16) begin
                    nbits = 0;
                    if (expq.size() == 0) begin
                        n_vec++;
                        n_bad++;
                        $display("FAIL R4 unexpected read: got %h expected none", word);
                    end else begin
                        exp_t e;
                        e = expq.pop_front();
                        check(e.tag, 32'(word), 32'(e.word));
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        tick(10);
        check("R1 busy in reset", 32'(busy), 32'd0);
        check("R1 so_oe in reset", 32'(so_oe), 32'd0);
        check("R1 autostore in reset", 32'(autostore_en), 32'd0);
        por_n = 1'b1;
        tick(4);
        check("R1 power-up recall busy", 32'(busy), 32'd1);
        wait_idle();
        check("R1 power-up recall ends", 32'(busy), 32'd0);
        rd(4'd0, SEED, "R1 word0", 1'b0, 0);
        rd(4'd15, SEED + 16'd15, "R1 word15", 1'b1, 0);
        check("R4 so_oe low when deselected", 32'(so_oe), 32'd0);

        // R6 write with flag clear
        wr(4'd2, 16'h1234);
        rd(4'd2, SEED + 16'd2, "R6 write without enable", 1'b0, 0);

        // R5 / R3
        cmd(C_WREN);
        wr(4'd2, 16'h1234);
        rd(4'd2, 16'h1234, "R5 write", 1'b0, 0);
        rd(4'd2, 16'h1234, "R3 leading zeros", 1'b1, 5);

        // R6 write-disable
        cmd(C_WRDIS);
        wr(4'd2, 16'hFFFF);
        rd(4'd2, 16'h1234, "R6 after disable", 1'b0, 0);

        // R7 store without recalled flag
        cmd(C_WREN);
        cmd(C_STORE);
        tick(20);
        check("R7 store refused", 32'(busy), 32'd0);

        // R8 software recall, R9 command during busy
        cmd(C_RCL);
        check("R8 recall busy", 32'(busy), 32'd1);
        cmd(C_WRDIS);
        check("R9 frame inside busy", 32'(busy), 32'd1);
        wait_idle();
        rd(4'd2, SEED + 16'd2, "R7 shadow untouched", 1'b0, 0);
        wr(4'd2, 16'hBEEF);
        rd(4'd2, 16'hBEEF, "R9 disable ignored", 1'b1, 0);

        // R7 store allowed, R10 flag cleared
        cmd(C_STORE);
        check("R7 store runs", 32'(busy), 32'd1);
        wait_idle();
        wr(4'd2, 16'h0000);
        rd(4'd2, 16'hBEEF, "R10 write after store", 1'b0, 0);

        // R8 hardware recall
        cmd(C_WREN);
        wr(4'd2, 16'h7777);
        rd(4'd2, 16'h7777, "R5 rewrite", 1'b0, 0);
        recall_n = 1'b0;
        tick(10);
        check("R8 pin recall busy", 32'(busy), 32'd1);
        recall_n = 1'b1;
        wait_idle();
        rd(4'd2, 16'hBEEF, "R8 pin recall data", 1'b0, 0);

        // R5 abort
        sel();
        send(32'(ins(4'd9, C_WRITE)), 8);
        send(32'hAA, 8);
        desel();
        rd(4'd9, SEED + 16'd9, "R5 aborted write", 1'b1, 0);

        // R11 stopped clock
        begin
            logic [7:0] w = ins(4'd9, C_WRITE);
            sel();
            send(32'(w[7:4]), 4);
            tick(300);
            send(32'(w[3:0]), 4);
            send(32'hC3, 8);
            tick(300);
            send(32'h3C, 8);
            desel();
        end
        rd(4'd9, 16'hC33C, "R11 paused clock", 1'b0, 0);

        // R2 address field and both read codes
        wr(4'd15, 16'h0F0F);
        wr(4'd0, 16'h8001);
        rd(4'd15, 16'h0F0F, "R2 addr15 code111", 1'b1, 0);
        rd(4'd0, 16'h8001, "R2 addr0 code110", 1'b0, 0);

        // R12 autostore flag
        check("R12 flag before", 32'(autostore_en), 32'd0);
        cmd(C_ASEN);
        check("R12 flag set", 32'(autostore_en), 32'd1);
        check("R12 no copy started", 32'(busy), 32'd0);
        rd(4'd9, 16'hC33C, "R12 memory unchanged", 1'b1, 0);
        cmd(C_WRDIS);
        check("R12 flag sticky", 32'(autostore_en), 32'd1);

        tick(20);
        check("R4 scoreboard drained", 32'(expq.size()), 32'd0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule